// File: doc/BRIEF.md
# Release-on-Access Interrupt Requester

This block turns the status of an output FIFO into a prioritised bus interrupt request. A single 16-bit configuration word sets three things: the request level (1 to 7, with 0 meaning off), the condition that triggers the request, and an 8-bit status/ID byte. The trigger condition is either FIFO half-full or FIFO not-empty. While the chosen condition holds, the active-low request line that matches the programmed level is pulled low.

The request is released on access, not on acknowledge. An acknowledge cycle does not drop the request. Only FIFO reads that clear the chosen condition withdraw it. When an acknowledge cycle arrives at the pending level, the block answers with the status/ID byte and a data-valid strobe. Any other acknowledge cycle is handed on to the next device through a pass flag, and no data is driven.

The request logic is a three-state machine:
- `ST_IDLE` means no request.
- `ST_PEND` means a request is raised and not yet acknowledged.
- `ST_SERVED` means a request has been acknowledged and is still held.

The transitions are:
- raise: `ST_IDLE` to `ST_PEND`, when the condition is true and the level is non-zero.
- acknowledge: `ST_PEND` to `ST_SERVED`, on a matching acknowledge cycle.
- release: `ST_PEND` or `ST_SERVED` to `ST_IDLE`, when the condition goes false or the level becomes 0.

Top module: `rora_interrupter`

## Requirements
- R1: The configuration word holds the level in bits 15..13, the condition select in bit 12 and the status/ID in bits 7..0. The written value is read back on `cfg_rdata` in the cycle after the write, with bits 11..8 always reading as 1.
- R2: With select 0, the condition is `fifo_half`=1, and `fifo_empty` has no effect. With select 1, the condition is `fifo_empty`=0, and `fifo_half` has no effect.
- R3: One clock after the condition becomes true at level L (1..7), `irq_n[L-1]` is 0 and every other bit of `irq_n` is 1.
- R4: An acknowledge cycle whose `iack_level` equals the pending level is answered one clock later with `ack_dv`=1, `ack_data`=status/ID and `ack_pass`=0. The answer is the same for every `iack_size` code: 0 for 8-bit, 1 for 16-bit, 2 for 32-bit.
- R5: Acknowledging does not remove the request. The request line returns to 1 one clock after the condition becomes false, i.e. after reads to empty in not-empty mode, or after reads below half in half-full mode.
- R6: After reset, `cfg_rdata` is 16'h0F00 (level 0, half-full select, ID 0), all `irq_n` bits are 1, and `ack_dv`, `ack_pass` and `ack_data` are 0.
- R7: When the level is 0, all `irq_n` bits stay 1 whatever the FIFO flags are.
- R8: An acknowledge cycle at a level that does not match, or one that arrives while no request is pending, gives `ack_pass`=1, `ack_dv`=0 and `ack_data`=0 one clock later.
- R9: `ack_dv` and `ack_pass` each last one clock per acknowledge cycle, and are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous module reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration readback |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_half | input | 1 | FIFO half-full flag |
| iack_valid | input | 1 | Acknowledge cycle strobe, one clock |
| iack_level | input | 3 | Level being acknowledged |
| iack_size | input | 2 | Acknowledge data width code |
| irq_n | output | 7 | Active-low request lines; bit i is level i+1 |
| ack_data | output | 8 | Status/ID answer |
| ack_dv | output | 1 | Answer valid |
| ack_pass | output | 1 | Acknowledge handed on |

## Verification
The bench sweeps every pairing of condition select, level 0..7 and the four FIFO flag combinations. This separates the two trigger sources, and shows that the flag not selected has no effect on the request. For each configuration, all eight acknowledge levels are issued across the three size codes. This separates a matching answer from a pass-on, both while a request is pending and while the block is idle. The condition is then dropped by a flag change that clears one mode but not the other. This shows that the request is released by the FIFO reads and not by the acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W   = 3;
    localparam int N_LINES = (1 << LVL_W) - 1;
    localparam int ID_W    = 8;
    localparam int REG_W   = 16;
    localparam int PAD_W   = REG_W - LVL_W - 1 - ID_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PEND   = 2'd1,
        ST_SERVED = 2'd2
    } req_state_e;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             sel_nempty;
        logic [ID_W-1:0]  status_id;
    } irq_cfg_t;
endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output irq_cfg_t         cfg,
    output logic [REG_W-1:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg.level      <= wdata[REG_W-1 -: LVL_W];
            cfg.sel_nempty <= wdata[REG_W-1-LVL_W];
            cfg.status_id  <= wdata[ID_W-1:0];
        end
    end

    always_comb begin
        rdata = {cfg.level, cfg.sel_nempty, {PAD_W{1'b1}}, cfg.status_id};
    end

    AST_PAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        &rdata[ID_W +: PAD_W]) // R1
        else $error("pad bits not ones");
endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cond,
    input  logic [LVL_W-1:0] level,
    input  logic             ack_hit,
    output logic             pending,
    output logic [N_LINES-1:0] irq_n
);
    req_state_e state_q, state_d;
    logic       enabled;

    always_comb begin
        enabled = (level != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cond && enabled) state_d = ST_PEND;          // raise
            end
            ST_PEND: begin
                if (!cond || !enabled) state_d = ST_IDLE;        // release
                else if (ack_hit)      state_d = ST_SERVED;      // acknowledge
            end
            ST_SERVED: begin
                if (!cond || !enabled) state_d = ST_IDLE;        // release
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q != ST_IDLE);
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        assign irq_n[g] = !(pending && (32'(level) == g + 1));
    end

    AST_HOLD_WHILE_COND: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && cond && enabled) |=> pending) // R5
        else $error("request dropped while condition holds");
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cond) |=> !pending) // R5
        else $error("request kept after condition cleared");
    AST_SERVED_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVED) |-> $past(state_q) != ST_IDLE) // R4
        else $error("served without pending");
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iack_valid,
    input  logic [LVL_W-1:0] iack_level,
    input  logic [1:0]       iack_size,
    input  logic             pending,
    input  irq_cfg_t         cfg,
    output logic             ack_hit,
    output logic [ID_W-1:0]  ack_data,
    output logic             ack_dv,
    output logic             ack_pass
);
    logic size_ok;

    always_comb begin
        // every width code gets the same byte answer
        size_ok = (iack_size <= 2'd3);
        ack_hit = iack_valid && size_ok && pending && (cfg.level != '0)
                  && (iack_level == cfg.level);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_data <= '0;
            ack_dv   <= 1'b0;
            ack_pass <= 1'b0;
        end else begin
            ack_dv   <= ack_hit;
            ack_pass <= iack_valid && !ack_hit;
            ack_data <= ack_hit ? cfg.status_id : '0;
        end
    end

    AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_dv && ack_pass)) // R9
        else $error("answer and pass together");
    AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        iack_valid |=> (ack_dv || ack_pass)) // R8
        else $error("acknowledge not answered");
    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !iack_valid |=> !(ack_dv || ack_pass)) // R9
        else $error("spurious answer");
    AST_PASS_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_dv |-> (ack_data == '0)) // R8
        else $error("data driven without valid");
endmodule

// File: rtl/rora_interrupter.sv
module rora_interrupter
    import irq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [15:0]  cfg_wdata,
    output logic [15:0]  cfg_rdata,
    input  logic         fifo_empty,
    input  logic         fifo_half,
    input  logic         iack_valid,
    input  logic [2:0]   iack_level,
    input  logic [1:0]   iack_size,
    output logic [6:0]   irq_n,
    output logic [7:0]   ack_data,
    output logic         ack_dv,
    output logic         ack_pass
);
    irq_cfg_t cfg;
    logic     cond;
    logic     pending;
    logic     ack_hit;

    irq_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    always_comb begin
        cond = cfg.sel_nempty ? !fifo_empty : fifo_half;
    end

    irq_req_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond    (cond),
        .level   (cfg.level),
        .ack_hit (ack_hit),
        .pending (pending),
        .irq_n   (irq_n)
    );

    irq_ack_unit u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .iack_valid (iack_valid),
        .iack_level (iack_level),
        .iack_size  (iack_size),
        .pending    (pending),
        .cfg        (cfg),
        .ack_hit    (ack_hit),
        .ack_data   (ack_data),
        .ack_dv     (ack_dv),
        .ack_pass   (ack_pass)
    );

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~irq_n)) // R3
        else $error("several request lines low");
    AST_LEVEL0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[15:13] == 3'd0) |-> (&irq_n)) // R7
        else $error("request at level 0");
endmodule

// File: tb/tb_rora_interrupter.sv
module tb_rora_interrupter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        fifo_empty = 1'b1;
    logic        fifo_half = 1'b0;
    logic        iack_valid = 1'b0;
    logic [2:0]  iack_level = '0;
    logic [1:0]  iack_size = '0;
    logic [6:0]  irq_n;
    logic [7:0]  ack_data;
    logic        ack_dv;
    logic        ack_pass;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rora_interrupter dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .fifo_empty(fifo_empty), .fifo_half(fifo_half),
        .iack_valid(iack_valid), .iack_level(iack_level), .iack_size(iack_size),
        .irq_n(irq_n), .ack_data(ack_data), .ack_dv(ack_dv), .ack_pass(ack_pass)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] exp_lines(input bit req, input int lvl);
        logic [6:0] v;
        v = 7'h7F;
        if (req && lvl != 0) v[lvl-1] = 1'b0;
        return v;
    endfunction

    task automatic write_cfg(input logic [15:0] w);
        cfg_we = 1'b1; cfg_wdata = w;
        step();
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R6 reset state
        check("R6 rdata", 32'(cfg_rdata), 32'h0F00);
        check("R6 irq_n", 32'(irq_n), 32'h7F);
        check("R6 ack", {ack_dv, ack_pass, ack_data}, 32'h0);
        rst_n = 1'b1;
        step();

        for (int sel = 0; sel < 2; sel++) begin
            for (int lvl = 0; lvl < 8; lvl++) begin
                for (int f = 0; f < 4; f++) begin
                    logic [7:0]  id;
                    logic [15:0] w;
                    bit e, h, cnd, req;
                    id = 8'(8'h41 + lvl * 16 + sel * 2 + f);
                    // quiet flags for both modes: empty, not half
                    fifo_empty = 1'b1; fifo_half = 1'b0;
                    step();
                    w = {3'(lvl), 1'(sel), 4'b0101, id};
                    write_cfg(w);
                    check("R1 readback", 32'(cfg_rdata), 32'({3'(lvl), 1'(sel), 4'hF, id}));
                    e = f[0]; h = f[1];
                    fifo_empty = e; fifo_half = h;
                    cnd = sel ? !e : h;
                    req = cnd && (lvl != 0);
                    step();
                    check(lvl == 0 ? "R7 level0" : "R2 R3 lines", 32'(irq_n), 32'(exp_lines(req, lvl)));
                    for (int a = 0; a < 8; a++) begin
                        bit hit;
                        hit = req && (a == lvl);
                        iack_valid = 1'b1; iack_level = 3'(a); iack_size = 2'(a % 3);
                        step();
                        iack_valid = 1'b0;
                        if (hit) check("R4 answer", {ack_dv, ack_pass, ack_data}, {22'd0, 2'b10, id});
                        else     check("R8 pass", {ack_dv, ack_pass, ack_data}, {22'd0, 2'b01, 8'h00});
                        step();
                        check("R9 pulse", {ack_dv, ack_pass}, 32'h0);
                        check("R5 held after ack", 32'(irq_n), 32'(exp_lines(req, lvl)));
                    end
                    if (req) begin
                        // reads clear the selected condition only
                        if (sel == 0) begin fifo_empty = 1'b0; fifo_half = 1'b0; end
                        else          begin fifo_empty = 1'b1; fifo_half = 1'b1; end
                        step();
                        check("R5 release", 32'(irq_n), 32'h7F);
                    end
                end
            end
        end

        // R2: non-selected flag has no effect while pending
        write_cfg({3'd4, 1'b1, 4'h0, 8'hC3});
        fifo_empty = 1'b0; fifo_half = 1'b0;
        step();
        check("R2 nempty ignores half", 32'(irq_n), 32'(exp_lines(1, 4)));
        write_cfg({3'd6, 1'b0, 4'h0, 8'h3C});
        step();
        check("R2 half mode not-empty only", 32'(irq_n), 32'h7F);

        // R6 reset with request pending
        write_cfg({3'd2, 1'b1, 4'h0, 8'h99});
        step();
        check("R3 before reset", 32'(irq_n), 32'(exp_lines(1, 2)));
        rst_n = 1'b0;
        #1;
        check("R6 reset irq", 32'(irq_n), 32'h7F);
        check("R6 reset cfg", 32'(cfg_rdata), 32'h0F00);
        step();
        rst_n = 1'b1;
        step();
        check("R6 after reset", 32'(irq_n), 32'h7F);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule